// File: doc/BRIEF.md
# ECC Error Capture and Reporting Unit

This unit watches a stream of ECC error events from a memory-side datapath and records them in two independent logs: one for correctable errors and one for uncorrectable errors. Each log holds a status word and a fault-address word. The first error of a class is the primary error. It records which transaction type hit it (programmed I/O, DMA read or DMA write) and freezes the context of that transfer: byte mask, doubleword offset, requester module ID, block flag, the syndrome for correctable errors, and the failing address. Errors that arrive later only mark a secondary cause bit. The context of the first failure is kept until software clears it.

A single-cycle 64-bit register port gives software access to a control word, the two status words and the two fault addresses. Software clears cause bits by writing ones to them. Each class drives its own interrupt line. An interrupt handler that finds no cause bit set in its class knows the interrupt did not come from that class.

Top module: `ecc_fault_log`

## Requirements
- R1: Control word (register index 0) holds a global check enable in bit 63, an uncorrectable interrupt enable in bit 62 and a correctable interrupt enable in bit 61. All three bits are writable, every other bit reads zero, and the word is zero after reset.
- R2: An event of a class that arrives while none of that class's primary bits (63:61) is set sets one primary bit. Kind code 0 (PIO) sets bit 63, code 1 (DMA read) sets bit 62 and code 2 (DMA write) sets bit 61. In the same update the event loads the byte mask into bits 47:32, the offset into 31:29, the module ID into 28:24, the block flag into bit 23 and the address into the class fault-address register. The new values are readable after the next clock edge.
- R3: An event that arrives while a primary bit of its class is set sets only the matching secondary bit: bit 60 for PIO, 59 for DMA read, 58 for DMA write. Context fields and fault address keep their values.
- R4: Writing 1 to a cause bit (63:58) of a status word clears that bit, and writing 0 leaves it unchanged. Writes do not change context fields or either fault-address register.
- R5: If a clearing write and a new event target the same cause bit in the same cycle, the bit stays set. The choice between primary and secondary uses the state held before that cycle.
- R6: While the global check enable is 0, no event changes any status word or fault address.
- R7: An event with kind code 3 is ignored.
- R8: Only the correctable log captures the 8-bit syndrome, in bits 55:48. The same bits of the uncorrectable status word read zero.
- R9: Each interrupt output is high exactly when some cause bit (63:58) of its class is set and that class's interrupt enable is 1.
- R10: Register indices are 0 control, 1 correctable status, 2 correctable address, 3 uncorrectable status and 4 uncorrectable address. Other indices read zero. Reserved status bits (57:56, 22:0, and 55:48 of the uncorrectable word) read zero.
- R11: An event selects its class with evt_uncorr (1 = uncorrectable). It never alters the log of the other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Error event strobe |
| evt_uncorr | input | 1 | Event class: 1 uncorrectable, 0 correctable |
| evt_kind | input | 2 | Transaction kind: 0 PIO, 1 DMA read, 2 DMA write, 3 none |
| evt_bmask | input | 16 | Byte mask of the failing transfer |
| evt_doff | input | 3 | Doubleword offset |
| evt_mid | input | 5 | Requester module ID |
| evt_blk | input | 1 | Transfer was a block operation |
| evt_synd | input | 8 | ECC syndrome (used by the correctable class only) |
| evt_addr | input | ADDR_W | Address of the failing transfer |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| irq_ce | output | 1 | Correctable error interrupt |
| irq_ue | output | 1 | Uncorrectable error interrupt |

## Verification
An event or write presented before a rising edge is visible in the status and address words after that edge. The interrupts follow in the same cycle, because they are combinational from registered state. Read data is combinational from reg_addr, so the bench drives every input on the falling edge and updates its model just after the rising edge. It then compares every register index and both interrupts at the next falling edge, one full edge after the stimulus. Directed cases cover disabled logging, primary and secondary capture, ignored writes and the same-bit collision. Seeded random traffic then checks every cycle against the model.

// File: rtl/ecc_log_pkg.sv
// Package: shared widths, transaction-kind encoding and captured-context type
// for the ECC error capture unit. Assumes a fixed 64-bit register layout.
package ecc_log_pkg;

    localparam int DW = 64;

    // Bit positions that software decodes; fixed by the register layout.
    localparam int CTRL_CHK_BIT = 63;
    localparam int CTRL_UIE_BIT = 62;
    localparam int CTRL_CIE_BIT = 61;
    localparam int PRI_TOP      = 63;   // primary causes 63..61
    localparam int SEC_TOP      = 60;   // secondary causes 60..58
    localparam int N_KIND       = 3;

    typedef enum logic [1:0] {
        KIND_PIO  = 2'd0,
        KIND_DRD  = 2'd1,
        KIND_DWR  = 2'd2,
        KIND_NONE = 2'd3
    } xact_kind_e;

    typedef struct packed {
        logic [7:0]  synd;
        logic [15:0] bmask;
        logic [2:0]  doff;
        logic [4:0]  mid;
        logic        blk;
    } err_ctx_t;

endpackage

// File: rtl/ecc_ctrl_reg.sv
// Module: control word holding the global check enable and the two class
// interrupt enables. Assumes the caller qualifies wen with the address match.
module ecc_ctrl_reg
    import ecc_log_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [2:0]    wbits,      // write data bits 63:61
    output logic          chk_en,
    output logic          ue_ien,
    output logic          ce_ien,
    output logic [DW-1:0] ctrl_word
);

    logic [2:0] en_q;

    // Hold the three enable bits; load them on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)   en_q <= '0;
        else if (wen) en_q <= wbits;
    end

    assign chk_en = en_q[2];
    assign ue_ien = en_q[1];
    assign ce_ien = en_q[0];

    // Place the enables at their fixed positions; every other bit reads zero.
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[CTRL_CHK_BIT] = en_q[2];
        ctrl_word[CTRL_UIE_BIT] = en_q[1];
        ctrl_word[CTRL_CIE_BIT] = en_q[0];
    end

endmodule

// File: rtl/ecc_class_log.sv
// Module: one error-class log. Keeps primary and secondary cause bits and the
// context frozen by the first error. Assumes evt is already qualified by class.
// KEEP_SYND selects whether the syndrome field is captured.
module ecc_class_log
    import ecc_log_pkg::*;
#(
    parameter bit KEEP_SYND = 1'b1,
    parameter int ADDR_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  logic              evt,
    input  xact_kind_e        kind,
    input  err_ctx_t          ctx,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              clr_wen,
    input  logic [5:0]        clr_bits,   // write data bits 63:58
    output logic [DW-1:0]     stat_word,
    output logic [DW-1:0]     addr_word,
    output logic              cause_any
);

    logic [N_KIND-1:0] pri_q, sec_q;
    logic [N_KIND-1:0] kind_oh, pri_set, sec_set, clr_pri, clr_sec;
    logic              hit, pri_busy;
    err_ctx_t          ctx_q, ctx_ld;
    logic [ADDR_W-1:0] addr_q;

    // Qualify the event and turn the kind into a one-hot cause vector.
    always_comb begin
        hit      = evt && log_en && (kind != KIND_NONE);
        kind_oh  = hit ? (N_KIND'(1) << kind) : '0;
        pri_busy = |pri_q;
        pri_set  = pri_busy ? '0 : kind_oh;
        sec_set  = pri_busy ? kind_oh : '0;
    end

    // Map written ones onto the cause bits (index 0 = PIO = highest bit).
    always_comb begin
        for (int i = 0; i < N_KIND; i++) begin
            clr_pri[i] = clr_wen && clr_bits[5 - i];
            clr_sec[i] = clr_wen && clr_bits[2 - i];
        end
    end

    // Cause bits: clear by write-one, then set by a new event (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            pri_q <= (pri_q & ~clr_pri) | pri_set;
            sec_q <= (sec_q & ~clr_sec) | sec_set;
        end
    end

    // Drop the syndrome for a class that does not keep one.
    always_comb begin
        ctx_ld = ctx;
        if (!KEEP_SYND) ctx_ld.synd = '0;
    end

    // Freeze context and address on a primary capture only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q  <= '0;
            addr_q <= '0;
        end else if (|pri_set) begin
            ctx_q  <= ctx_ld;
            addr_q <= fault_addr;
        end
    end

    // Assemble the status word; unlisted bits stay zero.
    always_comb begin
        stat_word = '0;
        for (int i = 0; i < N_KIND; i++) begin
            stat_word[PRI_TOP - i] = pri_q[i];
            stat_word[SEC_TOP - i] = sec_q[i];
        end
        stat_word[55:48] = ctx_q.synd;
        stat_word[47:32] = ctx_q.bmask;
        stat_word[31:29] = ctx_q.doff;
        stat_word[28:24] = ctx_q.mid;
        stat_word[23]    = ctx_q.blk;
    end

    assign addr_word = DW'(addr_q);
    assign cause_any = (|pri_q) | (|sec_q);

endmodule

// File: rtl/ecc_fault_log.sv
// Module: top of the ECC error capture unit. Splits events by class, hosts the
// control word and the two class logs, decodes the register port and gates the
// interrupts. Assumes at most one event per cycle and ADDR_W <= 64.
module ecc_fault_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic [1:0]        evt_kind,
    input  logic [15:0]       evt_bmask,
    input  logic [2:0]        evt_doff,
    input  logic [4:0]        evt_mid,
    input  logic              evt_blk,
    input  logic [7:0]        evt_synd,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_ce,
    output logic              irq_ue
);

    localparam int N_CLS   = 2;              // 0 correctable, 1 uncorrectable
    localparam int IDX_CTL = 0;
    localparam int IDX_LOG = 1;              // class c: status 1+2c, address 2+2c

    logic          chk_en, ue_ien, ce_ien;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] stat_w [N_CLS];
    logic [DW-1:0] addr_w [N_CLS];
    logic [N_CLS-1:0] cause_any;
    err_ctx_t      evt_ctx;
    logic          unused_wdata;

    assign evt_ctx      = '{synd: evt_synd, bmask: evt_bmask, doff: evt_doff,
                            mid: evt_mid, blk: evt_blk};
    assign unused_wdata = ^reg_wdata[57:0];

    ecc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (reg_wen && (reg_addr == REG_AW'(IDX_CTL))),
        .wbits     (reg_wdata[63:61]),
        .chk_en    (chk_en),
        .ue_ien    (ue_ien),
        .ce_ien    (ce_ien),
        .ctrl_word (ctrl_word)
    );

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        ecc_class_log #(
            .KEEP_SYND (c == 0),
            .ADDR_W    (ADDR_W)
        ) u_log (
            .clk        (clk),
            .rst_n      (rst_n),
            .log_en     (chk_en),
            .evt        (evt_valid && (evt_uncorr == c[0])),
            .kind       (xact_kind_e'(evt_kind)),
            .ctx        (evt_ctx),
            .fault_addr (evt_addr),
            .clr_wen    (reg_wen && (reg_addr == REG_AW'(IDX_LOG + 2 * c))),
            .clr_bits   (reg_wdata[63:58]),
            .stat_word  (stat_w[c]),
            .addr_word  (addr_w[c]),
            .cause_any  (cause_any[c])
        );
    end

    // Read mux: control, then status/address pairs per class; others read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(IDX_CTL)) reg_rdata = ctrl_word;
        for (int c = 0; c < N_CLS; c++) begin
            if (reg_addr == REG_AW'(IDX_LOG + 2 * c))     reg_rdata = stat_w[c];
            if (reg_addr == REG_AW'(IDX_LOG + 2 * c + 1)) reg_rdata = addr_w[c];
        end
    end

    // Interrupts: any cause of the class, gated by that class's enable.
    assign irq_ce = cause_any[0] && ce_ien;
    assign irq_ue = cause_any[1] && ue_ien;

endmodule

// File: rtl/ecc_fault_log_chk.sv
// Checker: temporal properties of the ECC error capture unit, bound to the top.
module ecc_fault_log_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic        evt_uncorr,
    input logic [1:0]  evt_kind,
    input logic [63:0] evt_addr_x,
    input logic        reg_wen,
    input logic [63:0] ctrl_word,
    input logic [63:0] ce_stat,
    input logic [63:0] ue_stat,
    input logic [63:0] ce_addr,
    input logic [63:0] ue_addr,
    input logic        irq_ce,
    input logic        irq_ue
);

    logic ce_hit, ue_hit;
    assign ce_hit = evt_valid && !evt_uncorr && ctrl_word[63] && (evt_kind != 2'd3);
    assign ue_hit = evt_valid &&  evt_uncorr && ctrl_word[63] && (evt_kind != 2'd3);

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hit && ce_stat[63:61] == 3'b0) |=>
            (ce_stat[63:61] != 3'b0 && ce_addr == $past(evt_addr_x)));

    p_secondary_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_hit && ue_stat[63:61] != 3'b0) |=>
            ($stable(ue_addr) && $stable(ue_stat[47:23]) && ue_stat[60:58] != 3'b0));

    p_addr_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> ($stable(ce_addr) && $stable(ue_addr)));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[63] && !reg_wen) |=> ($stable(ce_stat) && $stable(ue_stat)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_word[61] && irq_ue == irq_ue) |-> !irq_ce) and
        (!ctrl_word[62] |-> !irq_ue));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_stat[57:56] == 2'b0 && ce_stat[22:0] == 23'b0 &&
         ue_stat[57:48] == 10'b0 && ue_stat[22:0] == 23'b0 &&
         ctrl_word[60:0] == 61'b0));

    p_class_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_uncorr && !reg_wen) |=> $stable(ue_stat));

endmodule

bind ecc_fault_log ecc_fault_log_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_uncorr (evt_uncorr),
    .evt_kind   (evt_kind),
    .evt_addr_x (64'(evt_addr)),
    .reg_wen    (reg_wen),
    .ctrl_word  (ctrl_word),
    .ce_stat    (stat_w[0]),
    .ue_stat    (stat_w[1]),
    .ce_addr    (addr_w[0]),
    .ue_addr    (addr_w[1]),
    .irq_ce     (irq_ce),
    .irq_ue     (irq_ue)
);

// File: tb/ecc_fault_log_tb.sv
`timescale 1ns/1ps
module ecc_fault_log_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0, evt_uncorr = 1'b0, evt_blk = 1'b0;
    logic [1:0]  evt_kind = '0;
    logic [15:0] evt_bmask = '0;
    logic [2:0]  evt_doff = '0;
    logic [4:0]  evt_mid = '0;
    logic [7:0]  evt_synd = '0;
    logic [63:0] evt_addr = '0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_ce, irq_ue;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the register state.
    logic [63:0] m_ctrl;
    logic [63:0] m_stat [2];
    logic [63:0] m_addr [2];

    always #10 clk = ~clk;   // 50 MHz

    ecc_fault_log u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_uncorr(evt_uncorr),
        .evt_kind(evt_kind), .evt_bmask(evt_bmask), .evt_doff(evt_doff),
        .evt_mid(evt_mid), .evt_blk(evt_blk), .evt_synd(evt_synd),
        .evt_addr(evt_addr), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ce(irq_ce), .irq_ue(irq_ue)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model update from the state held before the edge.
    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            logic [63:0] nx;
            logic hit, busy;
            nx   = m_stat[c];
            hit  = evt_valid && (evt_uncorr == c[0]) && m_ctrl[63] && evt_kind != 2'd3;
            busy = |m_stat[c][63:61];
            if (reg_wen && reg_addr == 3'(1 + 2 * c))
                nx[63:58] = nx[63:58] & ~reg_wdata[63:58];
            if (hit) begin
                if (!busy) begin
                    nx[63 - evt_kind] = 1'b1;
                    nx[55:48] = (c == 0) ? evt_synd : 8'h00;
                    nx[47:32] = evt_bmask;
                    nx[31:29] = evt_doff;
                    nx[28:24] = evt_mid;
                    nx[23]    = evt_blk;
                    m_addr[c] = evt_addr;
                end else begin
                    nx[60 - evt_kind] = 1'b1;
                end
            end
            m_stat[c] = nx;
        end
        if (reg_wen && reg_addr == 3'd0)
            m_ctrl = {reg_wdata[63:61], 61'b0};
    endtask

    // Apply inputs at a falling edge, clock once, update the model, go idle.
    task automatic cyc(input logic ev, input logic unc, input logic [1:0] kd,
                       input logic [63:0] ad, input logic wen, input logic [2:0] wa,
                       input logic [63:0] wd);
        evt_valid = ev; evt_uncorr = unc; evt_kind = kd; evt_addr = ad;
        reg_wen = wen; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        evt_valid = 1'b0; reg_wen = 1'b0;
    endtask

    task automatic set_ctx(input logic [15:0] bm, input logic [2:0] dof,
                           input logic [4:0] md, input logic bk, input logic [7:0] sy);
        evt_bmask = bm; evt_doff = dof; evt_mid = md; evt_blk = bk; evt_synd = sy;
    endtask

    // Read every index and both interrupts against the model.
    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) begin
            logic [63:0] exp;
            reg_addr = 3'(a);
            #1;
            case (a)
                0: exp = m_ctrl;
                1: exp = m_stat[0];
                2: exp = m_addr[0];
                3: exp = m_stat[1];
                4: exp = m_addr[1];
                default: exp = '0;
            endcase
            check64($sformatf("%s idx%0d", req, a), reg_rdata, exp);
        end
        check64({req, " R9 irq_ce"}, {63'b0, irq_ce}, {63'b0, (|m_stat[0][63:58]) && m_ctrl[61]});
        check64({req, " R9 irq_ue"}, {63'b0, irq_ue}, {63'b0, (|m_stat[1][63:58]) && m_ctrl[62]});
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctrl = '0; m_stat[0] = '0; m_stat[1] = '0; m_addr[0] = '0; m_addr[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R6: logging disabled, event ignored
        set_ctx(16'hBEEF, 3'd5, 5'd9, 1'b1, 8'h3C);
        cyc(1, 0, 2'd1, 64'h1111_2222_3333_4440, 0, 0, 0);
        check_all("R6 disabled");

        // R1: only bits 63..61 stick
        cyc(0, 0, 0, 0, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check_all("R1 ctrl all ones");
        cyc(0, 0, 0, 0, 1, 3'd0, 64'h8000_0000_0000_0000);
        check_all("R1 check only");

        // R2/R8: primary correctable DMA read with syndrome, irq gated off
        cyc(1, 0, 2'd1, 64'hDEAD_BEEF_0000_1230, 0, 0, 0);
        check_all("R2 R8 primary ce");
        cyc(0, 0, 0, 0, 1, 3'd0, 64'hE000_0000_0000_0000);
        check_all("R9 enables on");

        // R3: later error sets secondary only
        set_ctx(16'h0001, 3'd1, 5'd2, 1'b0, 8'hAA);
        cyc(1, 0, 2'd0, 64'h0000_0000_0000_0008, 0, 0, 0);
        check_all("R3 secondary");

        // R11 R8: uncorrectable DMA write, syndrome not kept
        set_ctx(16'hF00F, 3'd7, 5'd31, 1'b1, 8'hFF);
        cyc(1, 1, 2'd2, 64'hCAFE_0000_0000_00F8, 0, 0, 0);
        check_all("R11 R8 primary ue");

        // R7: kind 3 ignored
        cyc(1, 1, 2'd3, 64'h5, 0, 0, 0);
        check_all("R7 kind none");

        // R4: zeros no effect; ones on context ignored; address writes ignored
        cyc(0, 0, 0, 0, 1, 3'd1, 64'h0);
        check_all("R4 write zero");
        cyc(0, 0, 0, 0, 1, 3'd1, 64'h03FF_FFFF_FFFF_FFFF);
        check_all("R4 context ro");
        cyc(0, 0, 0, 0, 1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        check_all("R4 addr ro");

        // R5: clear secondary DMA-read bit while a new DMA read hits it
        cyc(1, 0, 2'd1, 64'h77, 0, 0, 0);
        cyc(1, 0, 2'd1, 64'h99, 1, 3'd1, 64'h0800_0000_0000_0000);
        check_all("R5 collision");

        // R4: clear everything; interrupts drop
        cyc(0, 0, 0, 0, 1, 3'd1, 64'hFC00_0000_0000_0000);
        cyc(0, 0, 0, 0, 1, 3'd3, 64'hFC00_0000_0000_0000);
        check_all("R4 R9 cleared");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic wen;
            logic [2:0] wa;
            logic [63:0] wd;
            set_ctx(16'($urandom), 3'($urandom), 5'($urandom), 1'($urandom), 8'($urandom));
            wen = ($urandom % 4) == 0;
            wa  = 3'($urandom);
            wd  = {$urandom, $urandom};
            if (wa == 3'd0) wd[63] = ($urandom % 5) != 0;
            cyc(($urandom % 2) == 0, 1'($urandom), 2'($urandom), {$urandom, $urandom}, wen, wa, wd);
            check_all("R2 R3 R4 R5 R6 R7 R8 R10 R11 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule